// File: doc/BRIEF.md
# Dual-Inverter Reference Vector Distributor

This block sits between a drive's voltage-reference generator and the two pulse-width modulators of an open-winding drive. The winding is fed from both ends by two two-level inverters on separate, equal, galvanically isolated DC links. On each sample strobe it takes one reference vector in signed alpha/beta fixed-point form. It then produces one sub-vector for each inverter. The inverter-1 vector minus the inverter-2 vector gives back the reference. The block also sets a flag for any inverter that should hold a permanent zero vector, with all low-side switches on, and so form the winding's star point.

There are two splitting policies. The symmetrical policy gives each inverter half of the reference, with opposite phase. The asymmetrical policy lets one inverter, the main one, carry as much of the reference as its own hexagon allows. The reference is scaled radially onto that hexagon, and the other inverter supplies what is left. This covers three cases. Below a modulation index of one half the secondary inverter is clamped. Between one half and 1/sqrt(3) it is modulated only at angles where the reference leaves the main hexagon. Above 1/sqrt(3) both inverters always switch. The main role can be handed to the other inverter to even out wear. A request for this is held until the next fundamental-cycle boundary pulse, so the output fundamental stays continuous.

Values are Q1.(W-1) and are normalised so that 1.0 is the largest linear-region output of the pair. The single-inverter hexagon then has an inscribed radius of 0.5. The hexagon scale factor comes from a sequential divider. A result appears 2W-2+2 clock edges after an accepted strobe.

Top module: `dinv_ref_split`

## Requirements
- R1: For every result, inv1 minus inv2 equals the latched reference within 2 LSB in each of the alpha and beta components, in both policies.
- R2: With sym_mode_i = 1 at the strobe, inv1 = ref >>> 1 (an arithmetic halving, rounded toward minus infinity), inv2 = -(ref >>> 1), and both clamp flags are 0.
- R3: region_o reports 0 when alpha²+beta² is below (0.5)², 1 when it is below 1/3, and 2 otherwise. All three are in full-scale units.
- R4: With the asymmetrical policy and region 0, the main sub-vector equals the reference exactly, the secondary sub-vector is zero, and the secondary clamp flag is set.
- R5: With the asymmetrical policy, the main sub-vector is the reference scaled by min(1, 0.5/p) within 4 LSB. Here p is the largest absolute projection of the reference onto the unit normals at 30, 90 and 150 degrees.
- R6: With the asymmetrical policy, the secondary sub-vector is the remainder (reference minus main) within 4 LSB. Its clamp flag is set exactly when p does not exceed 0.5, and the main inverter's flag is never set.
- R7: With the asymmetrical policy and region 2, the secondary clamp flag is never set.
- R8: main_o is 0 when inverter 1 is main and 1 when inverter 2 is main. It changes only on a cycle_edge_i pulse that comes after a swap_req_i pulse. Several requests before one boundary give one toggle, and a boundary with no request leaves the role alone.
- R9: The policy and the main role are captured at the accepted strobe. Changes to either while the result is being computed do not affect that result. The main role maps as follows: main 0 drives inv1 = main and inv2 = -secondary; main 1 drives inv1 = secondary and inv2 = -main. Clamp bit 0 is inverter 1 and bit 1 is inverter 2.
- R10: valid_o pulses for exactly one cycle for each accepted strobe. A strobe that arrives while a result is still being computed is ignored.
- R11: After reset all sub-vectors, clamp flags, region_o, valid_o and main_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alpha_i | input | W | Reference alpha component, signed Q1.(W-1) |
| beta_i | input | W | Reference beta component, signed Q1.(W-1) |
| sample_i | input | 1 | Sample strobe that captures the reference, policy and role |
| sym_mode_i | input | 1 | 1 selects the symmetrical split, 0 selects the asymmetrical split |
| swap_req_i | input | 1 | Pulse that requests a main/secondary exchange |
| cycle_edge_i | input | 1 | Fundamental-cycle boundary pulse |
| inv1_alpha_o | output | W | Inverter 1 sub-vector alpha |
| inv1_beta_o | output | W | Inverter 1 sub-vector beta |
| inv2_alpha_o | output | W | Inverter 2 sub-vector alpha |
| inv2_beta_o | output | W | Inverter 2 sub-vector beta |
| clamp_o | output | 2 | Permanent zero-vector flags, bit 0 for inverter 1 and bit 1 for inverter 2 |
| region_o | output | 2 | Region code of the latched reference |
| main_o | output | 1 | Current main inverter, 0 for inverter 1 and 1 for inverter 2 |
| valid_o | output | 1 | One-cycle pulse that marks a new result |

## Verification
The embedded properties assume the reference stays inside the full-scale circle and that neither component takes the most negative code. Under that assumption halving, remainder and negation cannot wrap. The bench builds every stimulus from a magnitude of at most 0.98 and a rounded cosine/sine, so both conditions hold. It sweeps 24 angles and eight magnitudes, from zero up into the extended band, under both policies and both main roles. It checks the clamp flag only where the hexagon projection is clear of 0.5 by more than the fixed-point error. Strobes for the sweep are issued only after the previous result has appeared. The single busy-strobe case is driven on purpose to show that it is dropped.

// File: rtl/dinv_pkg.sv
package dinv_pkg;
  typedef enum logic [1:0] {
    REG_BASE  = 2'd0,
    REG_TRANS = 2'd1,
    REG_EXT   = 2'd2
  } region_e;
endpackage

// File: rtl/dinv_hex_proj.sv
module dinv_hex_proj
  import dinv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic signed [W-1:0] alpha_i,
  input  logic signed [W-1:0] beta_i,
  output logic        [W-1:0] peak_o,
  output region_e             region_o
);
  localparam int FB = W - 1;
  localparam int PW = 2 * W + 2;
  localparam longint C30 = longint'(0.8660254037844386 * (2.0 ** FB));
  localparam logic signed [PW-1:0] C30_S    = PW'(C30);
  localparam logic signed [PW-1:0] LIM_BASE = PW'(1) <<< (2 * FB - 2);
  localparam logic signed [PW-1:0] LIM_EXT  = PW'(1) <<< (2 * FB);
  localparam logic signed [PW-1:0] THREE    = PW'(3);

  logic signed [PW-1:0] a_w, b_w, a_c, b_h;
  logic signed [PW-1:0] s0, s1, s2, m0, m1, m2, pk01, peak_full, mag2;

  assign a_w = PW'(alpha_i);
  assign b_w = PW'(beta_i);
  assign a_c = a_w * C30_S;
  assign b_h = b_w <<< (FB - 1);

  // projections on the hexagon edge normals (30, 90, 150 deg), Q.2FB
  assign s0 = a_c + b_h;
  assign s1 = b_w <<< FB;
  assign s2 = b_h - a_c;
  assign m0 = s0[PW-1] ? -s0 : s0;
  assign m1 = s1[PW-1] ? -s1 : s1;
  assign m2 = s2[PW-1] ? -s2 : s2;
  assign pk01 = (m0 > m1) ? m0 : m1;
  assign peak_full = (pk01 > m2) ? pk01 : m2;
  assign peak_o = peak_full[FB+W-1:FB];

  logic unused_peak;
  assign unused_peak = ^{peak_full[PW-1:FB+W], peak_full[FB-1:0]};

  // region from squared magnitude, no root needed
  assign mag2 = a_w * a_w + b_w * b_w;
  always_comb begin
    if (mag2 < LIM_BASE)              region_o = REG_BASE;
    else if (THREE * mag2 < LIM_EXT)  region_o = REG_TRANS;
    else                              region_o = REG_EXT;
  end
endmodule

// File: rtl/dinv_div.sv
module dinv_div #(
  parameter int NW = 30,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [NW-1:0] num_i,
  input  logic [DW-1:0] den_i,
  output logic [NW-1:0] quo_o,
  output logic          busy_o,
  output logic          done_o
);
  localparam int CW = $clog2(NW + 1);

  logic [CW-1:0] cnt_q;
  logic [NW-1:0] sh_q, quo_q;
  logic [DW-1:0] rem_q, den_q;
  logic [DW:0]   trial, diff;
  logic          take, done_q;

  assign trial = {rem_q, sh_q[NW-1]};
  assign take  = trial >= {1'b0, den_q};
  assign diff  = trial - {1'b0, den_q};

  logic unused_diff;
  assign unused_diff = diff[DW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        cnt_q <= CW'(NW);
        sh_q  <= num_i;
        quo_q <= '0;
        rem_q <= '0;
        den_q <= den_i;
      end else if (cnt_q != '0) begin
        cnt_q  <= cnt_q - CW'(1);
        sh_q   <= sh_q << 1;
        quo_q  <= {quo_q[NW-2:0], take};
        rem_q  <= take ? diff[DW-1:0] : trial[DW-1:0];
        done_q <= (cnt_q == CW'(1));
      end
    end
  end

  assign quo_o  = quo_q;
  assign busy_o = cnt_q != '0;
  assign done_o = done_q;

  AST_DIV_REM_BELOW_DEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && den_q != '0) |-> rem_q < den_q); // R5
  AST_DIV_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R10
endmodule

// File: rtl/dinv_role.sv
module dinv_role (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic swap_req_i,
  input  logic cycle_edge_i,
  output logic main_o
);
  logic pend_q, main_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      main_q <= 1'b0;
    end else begin
      if (cycle_edge_i) begin
        if (pend_q) main_q <= ~main_q;
        pend_q <= swap_req_i;
      end else if (swap_req_i) begin
        pend_q <= 1'b1;
      end
    end
  end

  assign main_o = main_q;

  AST_ROLE_ONLY_AT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cycle_edge_i |=> $stable(main_q)); // R8
  AST_ROLE_NEEDS_REQUEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_edge_i && !pend_q) |=> $stable(main_q)); // R8
endmodule

// File: rtl/dinv_ref_split.sv
module dinv_ref_split
  import dinv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic signed [W-1:0] alpha_i,
  input  logic signed [W-1:0] beta_i,
  input  logic                sample_i,
  input  logic                sym_mode_i,
  input  logic                swap_req_i,
  input  logic                cycle_edge_i,
  output logic signed [W-1:0] inv1_alpha_o,
  output logic signed [W-1:0] inv1_beta_o,
  output logic signed [W-1:0] inv2_alpha_o,
  output logic signed [W-1:0] inv2_beta_o,
  output logic        [1:0]   clamp_o,
  output logic        [1:0]   region_o,
  output logic                main_o,
  output logic                valid_o
);
  localparam int FB = W - 1;
  localparam int NW = 2 * FB;
  localparam int PW = 2 * W + 2;
  localparam logic [W-1:0]  HALF = W'(1) << (FB - 1);
  localparam logic [W-1:0]  ONE  = W'(1) << FB;
  localparam logic [NW-1:0] NUM  = NW'(1) << (NW - 1);

  logic                busy_q, start_q, sym_q, role_q, valid_q;
  logic signed [W-1:0] cap_q [2];
  logic signed [W-1:0] ref_w [2];
  logic [1:0]          clamp_q, clamp_nx;
  logic [1:0]          region_q;
  logic                accept, main_w, sec_clamp;
  logic [W-1:0]        peak_w, scale;
  logic [NW-1:0]       quo_w;
  logic                div_busy, div_done;
  region_e             region_w;

  assign ref_w[0] = alpha_i;
  assign ref_w[1] = beta_i;
  assign accept   = sample_i && !busy_q;

  dinv_role u_role (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .swap_req_i  (swap_req_i),
    .cycle_edge_i(cycle_edge_i),
    .main_o      (main_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      sym_q   <= 1'b0;
      role_q  <= 1'b0;
      for (int k = 0; k < 2; k++) cap_q[k] <= '0;
    end else begin
      start_q <= accept;
      if (accept) begin
        busy_q <= 1'b1;
        sym_q  <= sym_mode_i;
        role_q <= main_w;
        for (int k = 0; k < 2; k++) cap_q[k] <= ref_w[k];
      end else if (div_done) begin
        busy_q <= 1'b0;
      end
    end
  end

  dinv_hex_proj #(.W(W)) u_proj (
    .alpha_i (cap_q[0]),
    .beta_i  (cap_q[1]),
    .peak_o  (peak_w),
    .region_o(region_w)
  );

  dinv_div #(.NW(NW), .DW(W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_q),
    .num_i  (NUM),
    .den_i  (peak_w),
    .quo_o  (quo_w),
    .busy_o (div_busy),
    .done_o (div_done)
  );

  logic unused_div;
  assign unused_div = ^{quo_w[NW-1:W], div_busy};

  // inside the hexagon the main inverter takes the reference unscaled
  assign scale     = (peak_w <= HALF) ? ONE : quo_w[W-1:0];
  assign sec_clamp = !sym_q && (peak_w <= HALF);
  assign clamp_nx  = role_q ? {1'b0, sec_clamp} : {sec_clamp, 1'b0};

  for (genvar k = 0; k < 2; k++) begin : g_lane
    logic signed [PW-1:0] prod;
    logic signed [W-1:0]  clip, rest, half, nx1, nx2, o1_q, o2_q;
    logic signed [W+1:0]  gap;

    assign prod = PW'(cap_q[k]) * PW'($signed({1'b0, scale}));
    assign clip = prod[FB+W-1:FB];
    assign rest = cap_q[k] - clip;
    assign half = cap_q[k] >>> 1;

    always_comb begin
      if (sym_q) begin
        nx1 = half;
        nx2 = -half;
      end else if (!role_q) begin
        nx1 = clip;
        nx2 = -rest;
      end else begin
        nx1 = rest;
        nx2 = -clip;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        o1_q <= '0;
        o2_q <= '0;
      end else if (div_done) begin
        o1_q <= nx1;
        o2_q <= nx2;
      end
    end

    logic unused_prod;
    assign unused_prod = ^{prod[PW-1:FB+W], prod[FB-1:0]};

    assign gap = (W+2)'(o1_q) - (W+2)'(o2_q) - (W+2)'(cap_q[k]);

    AST_SUM_MATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_q |-> (gap >= -2 && gap <= 2)); // R1
    AST_CAP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_q |=> $stable(cap_q[k])); // R10
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      clamp_q  <= '0;
      region_q <= '0;
    end else begin
      valid_q <= div_done;
      if (div_done) begin
        clamp_q  <= clamp_nx;
        region_q <= region_w;
      end
    end
  end

  assign inv1_alpha_o = g_lane[0].o1_q;
  assign inv1_beta_o  = g_lane[1].o1_q;
  assign inv2_alpha_o = g_lane[0].o2_q;
  assign inv2_beta_o  = g_lane[1].o2_q;
  assign clamp_o      = clamp_q;
  assign region_o     = region_q;
  assign main_o       = main_w;
  assign valid_o      = valid_q;

  AST_SYM_NO_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && sym_q) |-> clamp_q == 2'b00); // R2
  AST_CLAMP_ONE_SIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clamp_q)); // R6
  AST_CLAMP2_ZERO_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && clamp_q[1]) |-> (g_lane[0].o2_q == '0 && g_lane[1].o2_q == '0)); // R4
  AST_CLAMP1_ZERO_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && clamp_q[0]) |-> (g_lane[0].o1_q == '0 && g_lane[1].o1_q == '0)); // R4
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q); // R10
  AST_REGION_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    region_q != 2'd3); // R3
endmodule

// File: tb/dinv_ref_split_test.sv
module dinv_ref_split_test;
  localparam int  W   = 16;
  localparam real FS  = 32768.0;
  localparam real C30 = 0.8660254037844386;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                rst_n = 1'b0;
  logic signed [W-1:0] alpha = '0, beta = '0;
  logic                sample = 1'b0, sym = 1'b0, swap = 1'b0, cedge = 1'b0;
  logic signed [W-1:0] i1a, i1b, i2a, i2b;
  logic [1:0]          clamp, region;
  logic                main_r, valid;

  dinv_ref_split #(.W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .alpha_i(alpha), .beta_i(beta),
    .sample_i(sample), .sym_mode_i(sym), .swap_req_i(swap), .cycle_edge_i(cedge),
    .inv1_alpha_o(i1a), .inv1_beta_o(i1b), .inv2_alpha_o(i2a), .inv2_beta_o(i2b),
    .clamp_o(clamp), .region_o(region), .main_o(main_r), .valid_o(valid)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit exp_main = 1'b0, finished = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      n_fail++;
      $display("FAIL R10 watchdog expired: actual %0d cycles expected below 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic near(input string req, input string what, input int act,
                      input real exp, input real tol);
    real d;
    d = real'(act) - exp;
    if (d < 0.0) d = -d;
    chk(d <= tol, req, what, act, longint'(exp));
  endtask

  task automatic fire(input int a, input int b, input bit s);
    @(negedge clk);
    alpha  = W'(a);
    beta   = W'(b);
    sym    = s;
    sample = 1'b1;
    @(negedge clk);
    sample = 1'b0;
  endtask

  task automatic await_valid(output bit got);
    got = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (valid) begin
        got = 1'b1;
        break;
      end
    end
  endtask

  task automatic swap_role;
    @(negedge clk); swap = 1'b1;
    @(negedge clk); swap = 1'b0;
    chk(main_r == exp_main, "R8", "role before boundary", main_r, exp_main);
    @(negedge clk); swap = 1'b1;
    @(negedge clk); swap = 1'b0;
    repeat (3) @(negedge clk);
    chk(main_r == exp_main, "R8", "role after second request", main_r, exp_main);
    @(negedge clk); cedge = 1'b1;
    @(negedge clk); cedge = 1'b0;
    exp_main = ~exp_main;
    chk(main_r == exp_main, "R8", "role after boundary", main_r, exp_main);
    @(negedge clk); cedge = 1'b1;
    @(negedge clk); cedge = 1'b0;
    chk(main_r == exp_main, "R8", "boundary without request", main_r, exp_main);
  endtask

  task automatic run_vec(input int a, input int b, input bit s);
    bit got;
    real p0, p1, p2, pr, sc, ea, eb;
    int ma, mb, sa, sb, ereg;
    bit secc, mainc;
    longint mag2;
    fire(a, b, s);
    await_valid(got);
    chk(got, "R10", "result pulse", got, 1);
    if (!got) return;
    near("R1", "sum alpha", int'(i1a) - int'(i2a), real'(a), 2.0);
    near("R1", "sum beta", int'(i1b) - int'(i2b), real'(b), 2.0);
    mag2 = longint'(a) * a + longint'(b) * b;
    ereg = (mag2 < (64'sd1 <<< 28)) ? 0 : ((3 * mag2 < (64'sd1 <<< 30)) ? 1 : 2);
    chk(region == 2'(ereg), "R3", "region code", region, ereg);
    if (s) begin
      chk(i1a == W'(a >>> 1), "R2", "inv1 alpha half", i1a, a >>> 1);
      chk(i1b == W'(b >>> 1), "R2", "inv1 beta half", i1b, b >>> 1);
      chk(i2a == W'(-(a >>> 1)), "R2", "inv2 alpha half", i2a, -(a >>> 1));
      chk(i2b == W'(-(b >>> 1)), "R2", "inv2 beta half", i2b, -(b >>> 1));
      chk(clamp == 2'b00, "R2", "no clamp", clamp, 0);
    end else begin
      p0 = (real'(a) * C30 + real'(b) * 0.5) / FS;
      p1 = real'(b) / FS;
      p2 = (-real'(a) * C30 + real'(b) * 0.5) / FS;
      if (p0 < 0.0) p0 = -p0;
      if (p1 < 0.0) p1 = -p1;
      if (p2 < 0.0) p2 = -p2;
      pr = (p0 > p1) ? p0 : p1;
      pr = (pr > p2) ? pr : p2;
      sc = (pr > 0.5) ? 0.5 / pr : 1.0;
      ea = real'(a) * sc;
      eb = real'(b) * sc;
      // R9 role mapping
      if (!exp_main) begin
        ma = i1a; mb = i1b; sa = -int'(i2a); sb = -int'(i2b);
        secc = clamp[1]; mainc = clamp[0];
      end else begin
        ma = -int'(i2a); mb = -int'(i2b); sa = i1a; sb = i1b;
        secc = clamp[0]; mainc = clamp[1];
      end
      near("R5", "main alpha", ma, ea, 4.0);
      near("R5", "main beta", mb, eb, 4.0);
      near("R6", "secondary alpha", sa, real'(a) - ea, 4.0);
      near("R6", "secondary beta", sb, real'(b) - eb, 4.0);
      chk(!mainc, "R6", "main never clamped", mainc, 0);
      if (pr < 0.4995 || pr > 0.5005)
        chk(secc == (pr < 0.5), "R6", "secondary clamp", secc, pr < 0.5);
      if (ereg == 0) begin
        chk(ma == a && mb == b, "R4", "main exact alpha", ma, a);
        chk(sa == 0 && sb == 0, "R4", "secondary zero", sa, 0);
        chk(secc, "R4", "secondary clamped", secc, 1);
      end
      if (ereg == 2) chk(!secc, "R7", "both modulated", secc, 0);
    end
    @(negedge clk);
    chk(!valid, "R10", "pulse one cycle", valid, 0);
  endtask

  real mags [8] = '{0.0, 0.25, 0.49, 0.52, 0.56, 0.62, 0.8, 0.98};

  task automatic sweep(input bit s);
    real th;
    int a, b;
    for (int mi = 0; mi < 8; mi++) begin
      for (int ai = 0; ai < 24; ai++) begin
        th = real'(ai) * 15.0 * 3.141592653589793 / 180.0;
        a  = int'(mags[mi] * $cos(th) * 32767.0);
        b  = int'(mags[mi] * $sin(th) * 32767.0);
        run_vec(a, b, s);
      end
    end
  endtask

  initial begin
    bit got;
    int nvalid;
    repeat (4) @(negedge clk);
    chk(valid == 1'b0, "R11", "valid in reset", valid, 0);
    chk(main_r == 1'b0, "R11", "main in reset", main_r, 0);
    chk(clamp == 2'b00 && region == 2'b00, "R11", "flags in reset", {clamp, region}, 0);
    chk(i1a == 0 && i1b == 0 && i2a == 0 && i2b == 0, "R11", "vectors in reset", i1a, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    sweep(1'b0);
    sweep(1'b1);
    swap_role();
    sweep(1'b0);

    // R9: policy and role changes after the strobe do not touch the result
    fire(8000, -6000, 1'b1);
    sym = 1'b0;
    @(negedge clk); swap = 1'b1;
    @(negedge clk); swap = 1'b0; cedge = 1'b1;
    @(negedge clk); cedge = 1'b0;
    await_valid(got);
    chk(got && i1a == 16'sd4000 && i2b == 16'sd3000, "R9", "sampled policy", i1a, 4000);
    chk(clamp == 2'b00, "R9", "sampled policy clamp", clamp, 0);
    exp_main = ~exp_main;
    chk(main_r == exp_main, "R9", "role moved live", main_r, exp_main);

    // R10: busy strobe dropped
    fire(5000, 3000, 1'b0);
    repeat (3) @(negedge clk);
    fire(-9000, 1000, 1'b1);
    nvalid = 0;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (valid) begin
        nvalid++;
        if (!exp_main) chk(i1a == 16'sd5000 && i1b == 16'sd3000, "R10", "first kept", i1a, 5000);
        else chk(i2a == -16'sd5000 && i2b == -16'sd3000, "R10", "first kept", i2a, -5000);
      end
    end
    chk(nvalid == 1, "R10", "single result for busy strobe", nvalid, 1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule